// File: doc/BRIEF.md
# Multi-Channel Receive Reset Sequencer

This block drives the receive-side resets of a group of transceiver channels. A synchronous reset request puts every channel into analog and digital reset. Once the request drops, the analog reset stays on for a fixed number of clock cycles. The digital reset of each channel is then released only after the clock-and-data-recovery circuit reports lock to incoming data and a second hold time has run out. A per-channel ready flag follows one cycle later.

Both hold times are given in nanoseconds. They are turned into clock cycles by rounding up against the clock period parameter. A build-time switch selects one of two arrangements. In the first, each channel has its own digital reset counter, driven by its own lock signal. In the second, one shared counter uses the AND of all lock signals, so a single unlocked channel keeps every channel in digital reset. A run-time input selects the recovery policy after release. In auto policy, a later loss of lock puts the digital reset back on. In manual policy, loss of lock is ignored, so a supervisor can decide what to do.

Top module: `rx_reset_seq`

## Requirements
- R1: While `rst_req` is sampled high, every `analog_rst` and `digital_rst` bit is 1 from the following cycle and every `ready` bit is 0.
- R2: After `rst_req` is last sampled high, `analog_rst` stays 1 for exactly ceil(ANALOG_NS / CLK_PERIOD_NS) further clock edges, then goes to 0 (3 cycles with 20 ns at an 8 ns clock).
- R3: A channel's `digital_rst` never goes to 0 while `analog_rst` is 1. Its hold count of ceil(DIGITAL_NS / CLK_PERIOD_NS) edges runs only on edges where analog reset is off and the relevant lock is 1, and it restarts from full on any other edge.
- R4: In auto policy (`manual` = 0), a relevant lock sampled at 0 after release puts that controller's `digital_rst` back to 1 on the next cycle and restarts its hold count.
- R5: In manual policy (`manual` = 1), a lock loss after release leaves `digital_rst` at 0. Only `rst_req` re-asserts it.
- R6: With SHARED = 0, channel i's digital reset depends only on `locked[i]`. Other channels are unaffected.
- R7: With SHARED = 1, the relevant lock is the AND of all `locked` bits, and all `digital_rst` bits are held together.
- R8: `ready[i]` rises one cycle after `digital_rst[i]` falls, and drops in the same cycle in which `digital_rst[i]` rises again.
- R9: A `rst_req` pulse in the middle of a sequence restarts it from R1, including the full analog hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_req | input | 1 | Synchronous reset request, active high |
| manual | input | 1 | Recovery policy: 1 manual, 0 auto |
| locked | input | NUM_CH | Per-channel locked-to-data status |
| analog_rst | output | NUM_CH | Per-channel receive analog reset |
| digital_rst | output | NUM_CH | Per-channel receive digital reset |
| ready | output | NUM_CH | Per-channel receive ready |

## Verification
A lock loss can arrive in the very cycle in which a digital hold count would expire, or in the cycle in which a reset request lands. In the first case the count must reload rather than release. In the second, the request must win. Random lock toggling runs alongside sparse random reset pulses and policy flips, so these collisions occur many times. Each cycle is judged against a bench model that steps the analog hold, the digital hold and the ready lag from the requirements, for both a separate-counter and a shared-counter instance.

// File: rtl/rx_reset_seq.sv
module rx_reset_seq #(
  parameter int NUM_CH        = 4,
  parameter int CLK_PERIOD_NS = 8,
  parameter int ANALOG_NS     = 40,
  parameter int DIGITAL_NS    = 4000,
  parameter bit SHARED        = 1'b0
) (
  input  logic              clk,
  input  logic              rst_req,
  input  logic              manual,
  input  logic [NUM_CH-1:0] locked,
  output logic [NUM_CH-1:0] analog_rst,
  output logic [NUM_CH-1:0] digital_rst,
  output logic [NUM_CH-1:0] ready
);
  localparam int A_CYC = (ANALOG_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int D_CYC = (DIGITAL_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int AW    = $clog2(A_CYC + 1);
  localparam int DW    = $clog2(D_CYC + 1);
  localparam int NCTL  = SHARED ? 1 : NUM_CH;

  logic [AW-1:0]     acnt;
  logic              ana_hold;
  logic [NCTL-1:0]   ctl_lock;
  logic [NCTL-1:0]   ctl_hold;
  logic [NUM_CH-1:0] rdy_q;

  always_ff @(posedge clk) begin
    if (rst_req)            acnt <= AW'(A_CYC);
    else if (acnt != '0)    acnt <= acnt - 1'b1;
  end

  assign ana_hold   = (acnt != '0);
  assign analog_rst = {NUM_CH{ana_hold}};

  generate
    if (SHARED) begin : g_shared
      assign ctl_lock    = &locked;
      assign digital_rst = {NUM_CH{ctl_hold[0]}};
    end else begin : g_separate
      assign ctl_lock    = locked;
      assign digital_rst = ctl_hold;
    end

    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (rst_req)
          dcnt <= DW'(D_CYC);
        else if (dcnt != '0)
          dcnt <= (ana_hold || !ctl_lock[g]) ? DW'(D_CYC) : dcnt - 1'b1;
        else if (!manual && !ctl_lock[g])
          dcnt <= DW'(D_CYC);
      end
      assign ctl_hold[g] = (dcnt != '0);

      AST_AUTO_RELOCK: assert property (@(posedge clk) disable iff (rst_req)
        (!manual && !ctl_lock[g]) |=> ctl_hold[g]); // R4
      AST_MANUAL_KEEP: assert property (@(posedge clk) disable iff (rst_req)
        (manual && !ctl_hold[g]) |=> !ctl_hold[g]); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_req) rdy_q <= '0;
    else         rdy_q <= ~digital_rst;
  end

  assign ready = rdy_q & ~digital_rst;

  AST_REQ_FORCES: assert property (@(posedge clk)
    rst_req |=> (&analog_rst && &digital_rst && ready == '0)); // R1
  AST_DIG_AFTER_ANA: assert property (@(posedge clk) disable iff (rst_req)
    ana_hold |-> &digital_rst); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rdy_chk
    AST_READY_LAG: assert property (@(posedge clk) disable iff (rst_req)
      $fell(digital_rst[c]) |=> (ready[c] || digital_rst[c])); // R8
  end
endmodule

// File: tb/sim_rx_reset_seq.sv
module sim_rx_reset_seq;
  localparam int N  = 4;
  localparam int P  = 8;
  localparam int AN = 20;
  localparam int DN = 50;
  localparam int A  = (AN + P - 1) / P;
  localparam int D  = (DN + P - 1) / P;

  logic clk = 1'b0;
  logic rst_req = 1'b1, manual = 1'b0;
  logic [N-1:0] locked = '1;
  logic [N-1:0] a0, d0, r0, a1, d1, r1;
  int n_cmp = 0, n_bad = 0;
  bit model_on = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  rx_reset_seq #(.NUM_CH(N), .CLK_PERIOD_NS(P), .ANALOG_NS(AN), .DIGITAL_NS(DN), .SHARED(1'b0)) u0 (
    .clk(clk), .rst_req(rst_req), .manual(manual), .locked(locked),
    .analog_rst(a0), .digital_rst(d0), .ready(r0));
  rx_reset_seq #(.NUM_CH(N), .CLK_PERIOD_NS(P), .ANALOG_NS(AN), .DIGITAL_NS(DN), .SHARED(1'b1)) u1 (
    .clk(clk), .rst_req(rst_req), .manual(manual), .locked(locked),
    .analog_rst(a1), .digital_rst(d1), .ready(r1));

  int ma, mh;
  int ms [N];
  logic [N-1:0] mr_s, mr_h;

  function automatic int step_hold(int cur, bit ana, bit lk, bit man);
    if (cur != 0) return (ana || !lk) ? D : cur - 1;
    if (!man && !lk) return D;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] old_s;
    bit old_h, ana_old;
    old_h = (mh != 0);
    for (int i = 0; i < N; i++) old_s[i] = (ms[i] != 0);
    ana_old = (ma != 0);
    if (rst_req) begin
      ma = A; mh = D; mr_s = '0; mr_h = '0;
      for (int i = 0; i < N; i++) ms[i] = D;
    end else begin
      if (ma != 0) ma = ma - 1;
      mh = step_hold(mh, ana_old, &locked, manual);
      for (int i = 0; i < N; i++) ms[i] = step_hold(ms[i], ana_old, locked[i], manual);
      mr_s = ~old_s;
      mr_h = {N{~old_h}};
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    logic [N-1:0] es, eh;
    for (int i = 0; i < N; i++) es[i] = (ms[i] != 0);
    eh = {N{mh != 0}};
    chk("R2 analog sep", a0, {N{ma != 0}});
    chk("R2 analog shr", a1, {N{ma != 0}});
    chk("R6 digital sep", d0, es);
    chk("R7 digital shr", d1, eh);
    chk("R8 ready sep", r0, mr_s & ~es);
    chk("R8 ready shr", r1, mr_h & ~eh);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    model_on = 1'b1;
    chk("R1 analog in reset", a0, '1);
    chk("R1 digital in reset", d0, '1);
    chk("R1 ready in reset", r0, '0);
    rst_req = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (a0[0]);
    chk("R2 analog cycles", N'(cnt), N'(A));
    chk("R3 digital held at analog release", d0, '1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (d0[0]);
    chk("R3 digital cycles", N'(cnt), N'(D));
    chk("R8 ready not same cycle", r0, '0);
    @(negedge clk);
    chk("R8 ready next cycle", r0, '1);
    locked[1] = 1'b0;
    @(negedge clk);
    chk("R4 auto relock", d0, 4'b0010);
    chk("R6 other channels free", r0, 4'b1101);
    chk("R7 shared all held", d1, '1);
    locked[1] = 1'b1;
    repeat (D + 3) @(negedge clk);
    manual = 1'b1;
    locked[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 manual ignores loss", d0, '0);
    locked[2] = 1'b1;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk("R9 restart analog", a0, '1);
    chk("R9 restart digital", d1, '1);
    manual = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      rst_req = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 99) == 0) manual = ~manual;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 19) == 0) locked[i] = ~locked[i];
      if ($urandom_range(0, 49) == 0) locked = '1;
    end
    done = 1'b1;
    summary();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end
endmodule